// File: doc/BRIEF.md
# Reset Cause Status Register

This block merges the chip's reset sources into one system reset and keeps a record of which source caused the most recent reset. The sources are power-on detect, low-voltage detect, an active-low external reset pin, a watchdog timeout, an illegal-opcode event and a reset request from the clock module. Any qualified source starts a reset pulse. The pulse is stretched to a fixed length after the last active source. While the pulse is active, the block gathers every source it sees. When reset is released, it commits a new 8-bit cause value. The rule it applies depends on the kind of reset: power-on, low-voltage, or anything else.

Software reads the cause value as a read-only status word. Writing to the register's bus select does not change the stored cause bits. Instead, the write produces a one-cycle service pulse that restarts a small watchdog counter. The watchdog timeout feeds back into the reset logic, but only while the watchdog enable input is high. An illegal-opcode reset also fires when a stop instruction executes while stop is disabled, or when a background-entry instruction executes while debug is disabled.

Top module: `rst_cause_reg`

## Requirements
- R1: Status bit positions: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 2 clock module, bit 1 low voltage. Bits 3 and 0 always read 0.
- R2: Any qualified source that is active in a cycle sets `sys_rst_o` from the next cycle. `sys_rst_o` stays high for exactly 8 cycles after the last cycle with an active source.
- R3: If power-on was seen during the pulse, the committed status is 8'h82.
- R4: If low-voltage was seen during the pulse and power-on was not, bit 7 keeps its previous value, bit 1 is set and every other bit is 0. The other sources seen in the same pulse are ignored.
- R5: For any other reset, bits 7 and 1 are cleared. Bits 6, 5, 4 and 2 are each set exactly when their source was active in some cycle of the pulse.
- R6: A bus write (`bus_sel_i` and `bus_we_i` both high) raises `cop_kick_o` in the same cycle, restarts the watchdog count and leaves `status_o` unchanged.
- R7: The watchdog raises `cop_tmo_o` for one cycle after 2^COP_W cycles without a restart. The timeout starts a reset only while `cop_en_i` is 1. While `cop_en_i` is 0, the timeout leaves `sys_rst_o` at 0.
- R8: The illegal-opcode source is active when any of these holds: `illegal_op_i` is high; `stop_op_i` is high with `stop_en_i` low; `bgnd_op_i` is high with `dbg_en_i` low. A stop or background op with its enable high has no effect.
- R9: The external pin source is active when `pin_ni` is 0.
- R10: `status_o` changes only at the clock edge where `sys_rst_o` falls.
- R11: While `rst_ni` is low, `status_o` is 8'h82, `sys_rst_o` is 0 and the watchdog count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| por_i | input | 1 | Power-on detect |
| lvd_i | input | 1 | Low-voltage detect |
| pin_ni | input | 1 | External reset pin, active low |
| cop_en_i | input | 1 | Watchdog reset enable |
| illegal_op_i | input | 1 | Unimplemented opcode executed |
| stop_op_i | input | 1 | Stop instruction executed |
| stop_en_i | input | 1 | Stop permitted |
| bgnd_op_i | input | 1 | Background-entry instruction executed |
| dbg_en_i | input | 1 | Background debug permitted |
| icg_rst_i | input | 1 | Clock module reset request |
| bus_sel_i | input | 1 | Register selected on the bus |
| bus_we_i | input | 1 | Bus write strobe |
| sys_rst_o | output | 1 | Stretched system reset |
| status_o | output | 8 | Reset cause status word |
| cop_kick_o | output | 1 | Watchdog service pulse |
| cop_tmo_o | output | 1 | Watchdog timeout pulse |

## Verification
`sys_rst_o` rises one edge after a source is seen. It falls 9 edges after the last active source. The new status appears on that same falling edge. `cop_kick_o` follows the bus strobes within the same cycle. `cop_tmo_o` appears 2^COP_W edges after the last restart. The bench drives inputs just after the falling clock edge and compares every output 1 ns later against a behavioural model that it steps at each rising edge. Explicit checks then count the reset pulse length and compare the committed status word against constants taken from the requirements.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int B_POR  = 7;
  localparam int B_PIN  = 6;
  localparam int B_COP  = 5;
  localparam int B_ILOP = 4;
  localparam int B_ICG  = 2;
  localparam int B_LVD  = 1;
  localparam logic [7:0] POR_VAL = 8'h82;

  typedef struct packed {
    logic por;
    logic lvd;
    logic pin;
    logic cop;
    logic ilop;
    logic icg;
  } src_t;

  // priority: power-on, then low-voltage, then the rest
  function automatic logic [7:0] next_status(input src_t s, input logic cur_por);
    logic [7:0] v;
    v = '0;
    if (s.por) begin
      v = POR_VAL;
    end else if (s.lvd) begin
      v[B_POR] = cur_por;
      v[B_LVD] = 1'b1;
    end else begin
      v[B_PIN]  = s.pin;
      v[B_COP]  = s.cop;
      v[B_ILOP] = s.ilop;
      v[B_ICG]  = s.icg;
    end
    return v;
  endfunction
endpackage

// File: rtl/rst_src_qual.sv
module rst_src_qual
  import rst_cause_pkg::*;
(
  input  logic por_i,
  input  logic lvd_i,
  input  logic pin_ni,
  input  logic cop_tmo_i,
  input  logic cop_en_i,
  input  logic illegal_op_i,
  input  logic stop_op_i,
  input  logic stop_en_i,
  input  logic bgnd_op_i,
  input  logic dbg_en_i,
  input  logic icg_rst_i,
  output src_t src_o,
  output logic any_o
);
  always_comb begin
    src_o.por  = por_i;
    src_o.lvd  = lvd_i;
    src_o.pin  = ~pin_ni;
    src_o.cop  = cop_tmo_i & cop_en_i;
    src_o.ilop = illegal_op_i | (stop_op_i & ~stop_en_i) | (bgnd_op_i & ~dbg_en_i);
    src_o.icg  = icg_rst_i;
    any_o      = |src_o;
  end
endmodule

// File: rtl/rst_hold_ctl.sv
module rst_hold_ctl
  import rst_cause_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  src_t src_i,
  input  logic any_i,
  output logic rst_o,
  output logic commit_o,
  output src_t cause_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  src_t acc_q;

  assign rst_o    = (cnt_q != '0);
  assign commit_o = (cnt_q == CNT_W'(1)) && !any_i;
  assign cause_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (any_i) begin
      cnt_q <= CNT_W'(HOLD_CYC);
    end else if (rst_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // gather every source seen during the pulse, flush at commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (commit_o) begin
      acc_q <= '0;
    end else begin
      acc_q <= (rst_o ? acc_q : '0) | src_i;
    end
  end
endmodule

// File: rtl/cop_timer.sv
module cop_timer #(
  parameter int COP_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tmo_o
);
  logic [COP_W-1:0] cnt_q;

  assign tmo_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + COP_W'(1);
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int COP_W    = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       lvd_i,
  input  logic       pin_ni,
  input  logic       cop_en_i,
  input  logic       illegal_op_i,
  input  logic       stop_op_i,
  input  logic       stop_en_i,
  input  logic       bgnd_op_i,
  input  logic       dbg_en_i,
  input  logic       icg_rst_i,
  input  logic       bus_sel_i,
  input  logic       bus_we_i,
  output logic       sys_rst_o,
  output logic [7:0] status_o,
  output logic       cop_kick_o,
  output logic       cop_tmo_o
);
  src_t src;
  src_t cause;
  logic any_src;
  logic commit;
  logic [7:0] status_q;

  assign cop_kick_o = bus_sel_i & bus_we_i;

  rst_src_qual u_qual (
    .por_i       (por_i),
    .lvd_i       (lvd_i),
    .pin_ni      (pin_ni),
    .cop_tmo_i   (cop_tmo_o),
    .cop_en_i    (cop_en_i),
    .illegal_op_i(illegal_op_i),
    .stop_op_i   (stop_op_i),
    .stop_en_i   (stop_en_i),
    .bgnd_op_i   (bgnd_op_i),
    .dbg_en_i    (dbg_en_i),
    .icg_rst_i   (icg_rst_i),
    .src_o       (src),
    .any_o       (any_src)
  );

  rst_hold_ctl #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src),
    .any_i   (any_src),
    .rst_o   (sys_rst_o),
    .commit_o(commit),
    .cause_o (cause)
  );

  cop_timer #(.COP_W(COP_W)) u_cop (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cop_kick_o | sys_rst_o),
    .tmo_o (cop_tmo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= POR_VAL;
    end else if (commit) begin
      status_q <= next_status(cause, status_q[B_POR]);
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       lvd_i,
  input logic       pin_ni,
  input logic       bus_sel_i,
  input logic       bus_we_i,
  input logic       sys_rst_o,
  input logic [7:0] status_o,
  input logic       cop_kick_o,
  input logic       cop_tmo_o
);
  p_zero_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] == 1'b0) && (status_o[0] == 1'b0));

  p_quiet_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> ($past(pin_ni) && !$past(por_i) && !$past(lvd_i)));

  p_por_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> sys_rst_o);

  p_kick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_kick_o == (bus_sel_i && bus_we_i));

  p_tmo_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_tmo_o |=> !cop_tmo_o);

  p_pin_starts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_ni |=> sys_rst_o);

  p_commit_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sys_rst_o) |-> $stable(status_o));
endmodule

bind rst_cause_reg rst_cause_chk u_chk (.*);

// File: tb/rst_cause_reg_tb.sv
`timescale 1ns/1ps
module rst_cause_reg_tb;
  localparam int COP_W = 6;
  localparam int COP_MAX = (1 << COP_W) - 1;
  localparam int HOLD = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic por_i = 0, lvd_i = 0, pin_ni = 1, cop_en_i = 0, illegal_op_i = 0;
  logic stop_op_i = 0, stop_en_i = 1, bgnd_op_i = 0, dbg_en_i = 1, icg_rst_i = 0;
  logic bus_sel_i = 0, bus_we_i = 0;
  logic sys_rst_o, cop_kick_o, cop_tmo_o;
  logic [7:0] status_o;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_hold = 0;
  int m_cop = 0;
  logic [7:0] m_acc = '0;   // cause bits gathered in status positions
  logic [7:0] m_stat = 8'h82;

  always #4 clk_i = ~clk_i;

  rst_cause_reg #(.HOLD_CYC(HOLD), .COP_W(COP_W)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_src();
    logic [7:0] s;
    s = '0;
    s[7] = por_i;
    s[1] = lvd_i;
    s[6] = !pin_ni;
    s[5] = (m_cop == COP_MAX) && cop_en_i;
    s[4] = illegal_op_i || (stop_op_i && !stop_en_i) || (bgnd_op_i && !dbg_en_i);
    s[2] = icg_rst_i;
    return s;
  endfunction

  // compare, then advance one rising edge, then go to the falling edge
  task automatic step();
    logic [7:0] s;
    logic comm;
    #1;
    chk("R2 sys_rst", sys_rst_o, m_hold != 0);
    chk("R10 status", status_o, m_stat);
    chk("R6 kick", cop_kick_o, bus_sel_i && bus_we_i);
    chk("R7 tmo", cop_tmo_o, m_cop == COP_MAX);
    s = m_src();
    comm = (m_hold == 1) && (s == 0);
    @(posedge clk_i);
    if (comm) begin
      if (m_acc[7]) m_stat = 8'h82;
      else if (m_acc[1]) m_stat = {m_stat[7], 5'b0, 2'b10};
      else m_stat = {1'b0, m_acc[6:4], 1'b0, m_acc[2], 2'b00};
    end
    m_acc = comm ? 8'h00 : (((m_hold != 0) ? m_acc : 8'h00) | s);
    if ((bus_sel_i && bus_we_i) || (m_hold != 0)) m_cop = 0;
    else m_cop = (m_cop == COP_MAX) ? 0 : m_cop + 1;
    if (s != 0) m_hold = HOLD;
    else if (m_hold > 0) m_hold--;
    @(negedge clk_i);
  endtask

  task automatic idle();
    por_i = 0; lvd_i = 0; pin_ni = 1; illegal_op_i = 0;
    stop_op_i = 0; bgnd_op_i = 0; icg_rst_i = 0; bus_sel_i = 0; bus_we_i = 0;
  endtask

  // one-cycle stimulus already set by caller; then count the pulse
  task automatic fire_and_check(input string req, input logic [7:0] exp_stat);
    int n;
    step();
    idle();
    n = 0;
    while (sys_rst_o && n < 40) begin
      n++;
      step();
    end
    #1;
    chk({req, " pulse len R2"}, n, HOLD);
    chk({req, " status"}, status_o, exp_stat);
    chk({req, " zero bits R1"}, status_o & 8'h09, 0);
  endtask

  initial begin
    #1600000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    #1;
    chk("R11 reset status", status_o, 8'h82);
    chk("R11 reset sys_rst", sys_rst_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) step();

    // R9 external pin, R5 other-reset rule
    pin_ni = 0;
    fire_and_check("R9 R5 pin", 8'h40);

    // R6 bus write leaves status untouched
    bus_sel_i = 1; bus_we_i = 1;
    step();
    idle();
    step();
    #1;
    chk("R6 status after write", status_o, 8'h40);

    // R8 stop with stop enabled: no effect
    stop_op_i = 1; stop_en_i = 1;
    step();
    idle();
    step();
    #1;
    chk("R8 stop allowed no reset", sys_rst_o, 0);
    // R8 stop disabled
    stop_en_i = 0; stop_op_i = 1;
    fire_and_check("R8 stop", 8'h10);
    stop_en_i = 1;
    // R8 background entry with debug disabled
    dbg_en_i = 0; bgnd_op_i = 1;
    fire_and_check("R8 bgnd", 8'h10);
    dbg_en_i = 1;
    // R5 clock module
    icg_rst_i = 1;
    fire_and_check("R5 icg", 8'h04);
    // R5 sources spread across one pulse
    pin_ni = 0;
    step();
    idle();
    repeat (3) step();
    icg_rst_i = 1;
    fire_and_check("R5 pin+icg", 8'h44);
    // R4 low-voltage with bit 7 clear
    lvd_i = 1;
    fire_and_check("R4 lvd", 8'h02);
    // R3 power-on, with lvd together
    por_i = 1; lvd_i = 1;
    fire_and_check("R3 por", 8'h82);
    // R4 keeps bit 7, ignores pin
    lvd_i = 1; pin_ni = 0;
    fire_and_check("R4 lvd keeps por", 8'h82);

    // R7 timeout ignored while disabled
    cop_en_i = 0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 3 * (COP_MAX + 1); i++) begin
        step();
        if (sys_rst_o) seen++;
      end
      chk("R7 masked timeout", seen, 0);
    end
    // R6 regular kicks hold off an enabled watchdog
    bus_sel_i = 1; bus_we_i = 1;
    step();
    idle();
    cop_en_i = 1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 4 * (COP_MAX + 1); i++) begin
        if (i % 40 == 39) begin bus_sel_i = 1; bus_we_i = 1; end
        step();
        idle();
        if (sys_rst_o) seen++;
      end
      chk("R6 kicks prevent timeout", seen, 0);
    end
    // R7 enabled timeout resets
    begin
      int n;
      n = 0;
      while (!sys_rst_o && n < 2 * (COP_MAX + 1)) begin
        n++;
        step();
      end
      chk("R7 timeout reset", sys_rst_o, 1);
      n = 0;
      while (sys_rst_o && n < 40) begin
        n++;
        step();
      end
      #1;
      chk("R7 pulse len R2", n, HOLD);
      chk("R7 status", status_o, 8'h20);
    end
    cop_en_i = 0;
    repeat (4) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule